// File: doc/BRIEF.md
# Serial Interrupt Bus Short-Message Receiver

This receiver listens to a two-wire, wired-AND interrupt bus and follows one short message frame of 21 bus cycles: start, arbitration, eleven data cycles, checksum, postamble, two status cycles and a closing idle. Every value on the bus is sent complemented. The receiver complements each pair again and rebuilds the destination mode, delivery mode, level, trigger mode, 8-bit vector and 8-bit destination. It also keeps a running two-bit sum over the data cycles and compares it with the transmitted checksum.

In the first status cycle the receiver acts on the shared wires through its pull outputs. When its own checksum disagrees with the sender's, it pulls both wires low, which tells every node to drop the message. When focus operation is enabled, the message uses lowest-priority delivery and the destination addresses this node, it pulls only the upper wire low. That signals that the focus node has taken the interrupt. After the second status cycle the receiver gives one of two one-clock pulses: a field-valid strobe with the decoded fields, or a discard flag when any node reported a checksum error.

Top module: `irq_msg_rx`

## Requirements
- R1: While idle, the bus value 11 is ignored. The first clock that samples anything else is cycle 1 of a frame. One bus cycle lasts one clock, the frame lasts exactly 21 cycles, and a new frame may begin in the cycle directly after cycle 21.
- R2: Data pairs are taken as {wire1, wire0}, complemented, in this order. Cycle 6 gives {dest_mode, dlv_mode[2]}. Cycle 7 gives dlv_mode[1:0]. Cycle 8 gives {level, trig}. Cycles 9 to 12 give vector[7:0], most significant pair first. Cycles 13 to 16 give dest[7:0] in the same order.
- R3: The checksum is the sum, modulo 4, of the eleven complemented two-bit data pairs of cycles 6 to 16. It is compared with the complemented pair of cycle 17.
- R4: On a checksum mismatch, bus_pull is 11 (both wires pulled low) during cycle 19.
- R5: With focus_en high, a matching checksum, dlv_mode equal to 001 and an address hit, bus_pull is 10 (only wire 1 pulled low) during cycle 19. In every other case without a checksum error it is 00.
- R6: Address hit. In physical mode (dest_mode 0), dest[3:0] equals my_id, or dest[3:0] is all ones (broadcast). In logical mode (dest_mode 1), dest AND my_lid is non-zero.
- R7: fields_valid is high for exactly one clock, during cycle 21, when the bus value sampled in cycle 19 is not 00. The decoded fields are valid while it is high.
- R8: discard is high for exactly one clock, during cycle 21, when the bus value sampled in cycle 19 is 00. This includes errors signalled by other nodes. It is never high together with fields_valid.
- R9: After reset the receiver is idle, with bus_pull, fields_valid and discard all 0.
- R10: bus_pull is 00 in every cycle other than cycle 19, including while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 2 | Sampled wire levels {wire1, wire0}, wired-AND result |
| bus_pull | output | 2 | Per-wire pull-low enable |
| my_id | input | ID_W | Physical identity of this node |
| my_lid | input | 8 | Logical destination mask of this node |
| focus_en | input | 1 | Allows acceptance as focus for lowest-priority delivery |
| fields_valid | output | 1 | One-clock strobe, decoded fields valid |
| discard | output | 1 | One-clock flag, message dropped on checksum error |
| dest_mode | output | 1 | Decoded destination mode |
| dlv_mode | output | 3 | Decoded delivery mode |
| level | output | 1 | Decoded level bit |
| trig | output | 1 | Decoded trigger mode |
| vector | output | 8 | Decoded interrupt vector |
| dest | output | 8 | Decoded destination field |

## Verification
The hardest case to reach is a discard caused by another node's checksum error while this node's own checksum matches. The bench reaches it by having its sender model pull both wires low in cycle 19. A second hard case is focus acceptance that is blocked by a checksum error, where the pull must be 11 rather than 10. The bench reaches it by sending a lowest-priority message with a deliberately wrong checksum to an addressed focus node. Because the bench models the bus as the AND of its own drive and the receiver's pulls, the status that the receiver drives feeds back into its own fields_valid and discard decision.

// File: rtl/irq_msg_rx.sv
module irq_msg_rx #(
  parameter int          ID_W   = 4,
  parameter int          FRAME  = 21,
  parameter logic [2:0]  LOWPRI = 3'b001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      bus_in,
  output logic [1:0]      bus_pull,
  input  logic [ID_W-1:0] my_id,
  input  logic [7:0]      my_lid,
  input  logic            focus_en,
  output logic            fields_valid,
  output logic            discard,
  output logic            dest_mode,
  output logic [2:0]      dlv_mode,
  output logic            level,
  output logic            trig,
  output logic [7:0]      vector,
  output logic [7:0]      dest
);
  localparam int CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [CW-1:0] C_HDR  = CW'(6);
  localparam logic [CW-1:0] C_MOD  = CW'(7);
  localparam logic [CW-1:0] C_LT   = CW'(8);
  localparam logic [CW-1:0] C_V0   = CW'(9);
  localparam logic [CW-1:0] C_V1   = CW'(12);
  localparam logic [CW-1:0] C_D0   = CW'(13);
  localparam logic [CW-1:0] C_D1   = CW'(16);
  localparam logic [CW-1:0] C_CSUM = CW'(17);
  localparam logic [CW-1:0] C_POST = CW'(18);
  localparam logic [CW-1:0] C_ST0  = CW'(19);
  localparam logic [CW-1:0] C_ST1  = CW'(20);
  localparam logic [CW-1:0] C_LAST = CW'(FRAME);

  logic [CW-1:0] cnt, cyc;
  logic [1:0]    rx, sum, st0;
  logic          csum_err, addr_hit, focus_hit;

  assign rx  = ~bus_in;
  assign cyc = (cnt == '0 && bus_in != 2'b11) ? C_ONE : cnt;

  assign addr_hit  = dest_mode ? |(dest & my_lid)
                               : (dest[ID_W-1:0] == my_id) || (&dest[ID_W-1:0]);
  assign focus_hit = focus_en && (dlv_mode == LOWPRI) && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      sum          <= '0;
      st0          <= 2'b11;
      csum_err     <= 1'b0;
      bus_pull     <= 2'b00;
      fields_valid <= 1'b0;
      discard      <= 1'b0;
      dest_mode    <= 1'b0;
      dlv_mode     <= '0;
      level        <= 1'b0;
      trig         <= 1'b0;
      vector       <= '0;
      dest         <= '0;
    end else begin
      fields_valid <= 1'b0;
      discard      <= 1'b0;
      if (cyc != '0)
        cnt <= (cyc == C_LAST) ? '0 : cyc + C_ONE;
      if (cyc >= C_HDR && cyc <= C_D1)
        sum <= sum + rx;
      if (cyc == C_ONE) begin
        sum      <= '0;
        csum_err <= 1'b0;
      end
      if (cyc == C_HDR) begin
        dest_mode   <= rx[1];
        dlv_mode[2] <= rx[0];
      end
      if (cyc == C_MOD)
        dlv_mode[1:0] <= rx;
      if (cyc == C_LT) begin
        level <= rx[1];
        trig  <= rx[0];
      end
      if (cyc >= C_V0 && cyc <= C_V1)
        vector <= {vector[5:0], rx};
      if (cyc >= C_D0 && cyc <= C_D1)
        dest <= {dest[5:0], rx};
      if (cyc == C_CSUM)
        csum_err <= (sum != rx);
      if (cyc == C_POST)
        bus_pull <= csum_err ? 2'b11 : (focus_hit ? 2'b10 : 2'b00);
      if (cyc == C_ST0) begin
        bus_pull <= 2'b00;
        st0      <= bus_in;
      end
      if (cyc == C_ST1) begin
        fields_valid <= (st0 != 2'b00);
        discard      <= (st0 == 2'b00);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= C_LAST); // R1
  AST_PULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (bus_pull != 2'b00) |-> (cnt == C_ST0)); // R10
  AST_ERR_BOTH: assert property (@(posedge clk) disable iff (!rst_n) (cnt == C_ST0 && csum_err) |-> (bus_pull == 2'b11)); // R4
  AST_FOCUS_CODE: assert property (@(posedge clk) disable iff (!rst_n) (cnt == C_ST0 && !csum_err && bus_pull != 2'b00) |-> (bus_pull == 2'b10)); // R5
  AST_VALID_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (fields_valid || discard) |-> (cnt == C_LAST)); // R7
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fields_valid |=> !fields_valid); // R7
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fields_valid && discard)); // R8
endmodule

// File: tb/test_irq_msg_rx.sv
module test_irq_msg_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] drv = 2'b11;
  logic [1:0] bus_in, bus_pull;
  logic [3:0] my_id = 4'h5;
  logic [7:0] my_lid = 8'h24;
  logic       focus_en = 1'b0;
  logic       fields_valid, discard, dest_mode, level, trig;
  logic [2:0] dlv_mode;
  logic [7:0] vector, dest;
  int checks = 0, fails = 0;
  logic [23:0] expq[$];

  always #5 clk = ~clk;
  assign bus_in = drv & ~bus_pull;

  irq_msg_rx i_irq_msg_rx (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_pull(bus_pull),
    .my_id(my_id), .my_lid(my_lid), .focus_en(focus_en),
    .fields_valid(fields_valid), .discard(discard), .dest_mode(dest_mode),
    .dlv_mode(dlv_mode), .level(level), .trig(trig), .vector(vector), .dest(dest));

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic dm, input logic [2:0] md, input logic l, input logic tm,
                      input logic [7:0] v, input logic [7:0] d, input bit bad, input bit oth);
    logic [1:0] p[11];
    logic [1:0] s, ep, st;
    bit hit;
    p[0] = {dm, md[2]}; p[1] = md[1:0]; p[2] = {l, tm};
    p[3] = v[7:6]; p[4] = v[5:4]; p[5] = v[3:2]; p[6] = v[1:0];
    p[7] = d[7:6]; p[8] = d[5:4]; p[9] = d[3:2]; p[10] = d[1:0];
    s = 2'b00;
    for (int i = 0; i < 11; i++) s = s + p[i];
    hit = dm ? ((d & my_lid) != 0) : (d[3:0] == my_id || d[3:0] == 4'hF);
    ep = bad ? 2'b11 : ((focus_en && md == 3'b001 && hit) ? 2'b10 : 2'b00);
    st = (oth ? 2'b00 : 2'b11) & ~ep;
    expq.push_back({dm, md, l, tm, v, d, st != 2'b00, st == 2'b00});
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      if (k == 1) drv = 2'b01;
      else if (k <= 5) drv = 2'b10;
      else if (k <= 16) drv = ~p[k-6];
      else if (k == 17) drv = ~(bad ? s + 2'b01 : s);
      else if (k == 19) drv = oth ? 2'b00 : 2'b11;
      else drv = 2'b11;
      if (k == 19) check(bus_pull == ep, "R4 R5 R6 status pull", 24'(bus_pull), 24'(ep));
      else if (bus_pull != 2'b00) check(1'b0, "R10 pull outside status cycle", 24'(bus_pull), 24'h0);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && (fields_valid || discard)) begin
        logic [23:0] act;
        act = {dest_mode, dlv_mode, level, trig, vector, dest, fields_valid, discard};
        if (expq.size() == 0) check(1'b0, "R1 R7 R8 unexpected strobe", act, 24'h0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          check(act == e, "R2 R3 R7 R8 fields/flags", act, e);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : driver
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    check(bus_pull == 0 && !fields_valid && !discard, "R9 reset state",
          {bus_pull, fields_valid, discard}, 24'h0);
    rst_n = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (bus_pull != 0 || fields_valid || discard)
        check(1'b0, "R1 R10 idle activity", {bus_pull, fields_valid, discard}, 24'h0);
    end
    check(1'b1, "R1 idle ignored", 24'h0, 24'h0);
    send(1'b0, 3'b000, 1'b1, 1'b0, 8'hA5, 8'h05, 1'b0, 1'b0);
    send(1'b1, 3'b100, 1'b0, 1'b1, 8'h3C, 8'hF0, 1'b0, 1'b0);
    send(1'b0, 3'b000, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0);
    send(1'b0, 3'b010, 1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0, 1'b1);
    focus_en = 1'b1;
    send(1'b0, 3'b001, 1'b0, 1'b0, 8'h41, 8'h05, 1'b0, 1'b0);
    send(1'b0, 3'b001, 1'b0, 1'b0, 8'h42, 8'h0F, 1'b0, 1'b0);
    send(1'b0, 3'b001, 1'b0, 1'b0, 8'h43, 8'h06, 1'b0, 1'b0);
    send(1'b1, 3'b001, 1'b1, 1'b0, 8'h44, 8'h20, 1'b0, 1'b0);
    send(1'b1, 3'b001, 1'b1, 1'b0, 8'h45, 8'h81, 1'b0, 1'b0);
    send(1'b0, 3'b000, 1'b0, 1'b0, 8'h46, 8'h05, 1'b0, 1'b0);
    send(1'b0, 3'b001, 1'b0, 1'b0, 8'h47, 8'h05, 1'b1, 1'b0);
    lf = 8'h1D;
    for (int n = 0; n < 12; n++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      send(lf[0], {lf[3:2], lf[1]}, lf[4], lf[5], lf ^ 8'h5A, {lf[7:4], 4'(lf[3:0] ^ 4'h3)},
           lf[6] & lf[2], lf[7] & lf[1] & ~lf[0]);
    end
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R7 R8 every frame reported", 24'(expq.size()), 24'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule